// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block keeps the write-enable latch and the protection bits of a serial EEPROM. It decides whether each array program request or status-register update may go ahead. An upstream command decoder feeds it one-cycle instruction strobes: enable writes, disable writes, read status, write status and program. With those strobes it supplies a program target address, the new status value, the level of the write-protect pin, and a busy flag from the write-cycle timer.

For a program request the block answers with a one-cycle grant or deny pulse. An accepted status write raises a one-cycle start pulse, which the timer uses to run the nonvolatile update cycle. A read-status strobe captures the status byte into a register that the serial shifter then sends out.

Array protection splits the address space into quarters using the top two address bits, so the array size is set by one address-width parameter.

Top module: `eeprom_wprot`

## Requirements
- R1: After reset the enable latch, both protection bits and the protect-enable bit are 0, `statusOut` is 0x00, and no grant, deny or start pulse is present.
- R2: A write-enable strobe taken while not busy sets the enable latch, which shows as bit 1 of the status byte.
- R3: A write-disable strobe taken while not busy clears the enable latch, whatever the level of `wpPin`.
- R4: A read-status strobe captures the status byte into `statusOut`, visible from the cycle after the strobe. When not busy the byte is: bit 7 protect-enable, bits 6..4 zero, bit 3 level high bit, bit 2 level low bit, bit 1 enable latch, bit 0 zero.
- R5: A read-status strobe taken while `busy` is high captures 0xFF.
- R6: A program request taken while the enable latch is clear gets a deny pulse in the following cycle.
- R7: With the enable latch set, a program request is denied when its address is protected and granted otherwise. Level 00 protects nothing, 01 protects addresses whose top two bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address. For 14 address bits these ranges are 0x3000-0x3FFF, 0x2000-0x3FFF and the whole array.
- R8: Every program request that is granted or denied clears the enable latch.
- R9: A write-status strobe with the enable latch set loads bits 7, 3 and 2 of `statData` into protect-enable and the level bits, pulses `statStart` in the next cycle, and clears the latch. With the latch clear, the strobe changes no protection bit, gives no pulse, and leaves the latch clear.
- R10: While protect-enable is 1 and `wpPin` is low, a write-status request is refused: the latch clears, no start pulse is given, and the bits stay as they are. Array protection still depends only on the level bits.
- R11: While `busy` is high, every strobe other than read-status is ignored. It changes no state and produces no pulse.
- R12: When several strobes arrive in one cycle, write-disable takes priority over write-enable, which takes priority over write-status, which takes priority over program. Only the winning instruction acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write-enable instruction strobe |
| cmdWrDis | input | 1 | Write-disable instruction strobe |
| cmdRdStat | input | 1 | Read-status instruction strobe |
| cmdWrStat | input | 1 | Write-status instruction strobe |
| cmdProg | input | 1 | Array program request strobe |
| progAddr | input | ADDR_W | Target address of the program request |
| statData | input | 8 | New status value for write-status |
| wpPin | input | 1 | Write-protect pin level (low = asserted) |
| busy | input | 1 | Internal write cycle in progress |
| statusOut | output | 8 | Captured status byte for the shifter |
| progGrant | output | 1 | Program request accepted (one cycle) |
| progDeny | output | 1 | Program request refused (one cycle) |
| statStart | output | 1 | Start a status-register write cycle (one cycle) |

## Verification
The bench builds the block with ADDR_W = 14, which models a 16K-byte array. At that width the exact quarter and half boundaries (0x2FFF/0x3000 and 0x1FFF/0x2000) can be hit on both sides, and the top and bottom addresses can be tested at every protection level. The narrow address also keeps the vector table short while still covering the protect-enable and pin interaction and requests made while busy.

// File: rtl/eeprom_wprot_pkg.sv
package eeprom_wprot_pkg;

  localparam int STAT_W    = 8;
  localparam int WPEN_POS  = 7;
  localparam int LVL_HI    = 3;
  localparam int LVL_LO    = 2;

  typedef struct packed {
    logic setWen;
    logic clrWen;
    logic loadStat;
    logic capStat;
  } wpStrobe_t;

endpackage

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
  import eeprom_wprot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEn,
  input  logic      cmdWrDis,
  input  logic      cmdRdStat,
  input  logic      cmdWrStat,
  input  logic      cmdProg,
  input  logic      busy,
  input  logic      wpPin,
  input  logic      wenIn,
  input  logic      wpenIn,
  input  logic      inProt,
  output wpStrobe_t stb,
  output logic      progGrant,
  output logic      progDeny,
  output logic      statStart
);

  logic statLocked;
  logic grantD, denyD, startD;

  assign statLocked = wpenIn && !wpPin;

  always_comb begin
    stb         = '0;
    grantD      = 1'b0;
    denyD       = 1'b0;
    startD      = 1'b0;
    stb.capStat = cmdRdStat;
    if (!busy) begin
      if (cmdWrDis) begin
        stb.clrWen = 1'b1;
      end else if (cmdWrEn) begin
        stb.setWen = 1'b1;
      end else if (cmdWrStat) begin
        stb.clrWen = 1'b1;
        if (wenIn && !statLocked) begin
          stb.loadStat = 1'b1;
          startD       = 1'b1;
        end
      end else if (cmdProg) begin
        stb.clrWen = 1'b1;
        if (wenIn && !inProt) grantD = 1'b1;
        else                  denyD  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progGrant <= 1'b0;
      progDeny  <= 1'b0;
      statStart <= 1'b0;
    end else begin
      progGrant <= grantD;
      progDeny  <= denyD;
      statStart <= startD;
    end
  end

  // R6: a grant only follows a cycle with the latch set
  a_r6_grant_needs_wen: assert property (@(posedge clk) disable iff (!rstN)
    progGrant |-> $past(wenIn));

  // R8: latch is already clear when any result pulse appears
  a_r8_result_clears_wen: assert property (@(posedge clk) disable iff (!rstN)
    (progGrant || progDeny || statStart) |-> !wenIn);

  // R7: a protected address is never granted
  a_r7_protected_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    (cmdProg && !busy && inProt) |=> !progGrant);

  // R10: locked status register never starts a write
  a_r10_locked_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrStat && wpenIn && !wpPin) |=> !statStart);

  // R12: at most one result pulse per cycle
  a_r12_single_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progGrant, progDeny, statStart}));

  // R11: no result follows a busy cycle
  a_r11_busy_no_result: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(progGrant || progDeny || statStart));

endmodule

// File: rtl/eeprom_wprot_dp.sv
module eeprom_wprot_dp
  import eeprom_wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         stb,
  input  logic              busy,
  input  logic [STAT_W-1:0] statData,
  input  logic [ADDR_W-1:0] progAddr,
  output logic              wen,
  output logic              wpen,
  output logic              inProt,
  output logic [STAT_W-1:0] statusOut
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0]        lvl;
  logic [1:0]        topBits;
  logic [STAT_W-1:0] liveStat;
  logic              unusedStatBits;

  assign unusedStatBits = ^{statData[6:4], statData[1:0]};
  assign topBits        = progAddr[TOP -: 2];

  always_comb begin
    unique case (lvl)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (topBits == 2'b11);
      2'b10:   inProt = topBits[1];
      default: inProt = 1'b1;
    endcase
  end

  assign liveStat = busy ? {STAT_W{1'b1}} : {wpen, 3'b000, lvl, wen, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wen       <= 1'b0;
      wpen      <= 1'b0;
      lvl       <= 2'b00;
      statusOut <= '0;
    end else begin
      if (stb.setWen)      wen <= 1'b1;
      else if (stb.clrWen) wen <= 1'b0;
      if (stb.loadStat) begin
        wpen <= statData[WPEN_POS];
        lvl  <= {statData[LVL_HI], statData[LVL_LO]};
      end
      if (stb.capStat) statusOut <= liveStat;
    end
  end

  // R11: state is frozen across a busy cycle
  a_r11_busy_freezes: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(wen) && $stable(lvl) && $stable(wpen)));

  // R5: read during busy returns all ones
  a_r5_busy_reads_ones: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capStat && busy) |=> (statusOut == 8'hFF));

  // R4: idle read has zero filler bits and ready flag
  a_r4_idle_layout: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capStat && !busy) |=> (statusOut[6:4] == 3'b000 && !statusOut[0]));

endmodule

// File: rtl/eeprom_wprot.sv
module eeprom_wprot
  import eeprom_wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              cmdWrDis,
  input  logic              cmdRdStat,
  input  logic              cmdWrStat,
  input  logic              cmdProg,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        statData,
  input  logic              wpPin,
  input  logic              busy,
  output logic [7:0]        statusOut,
  output logic              progGrant,
  output logic              progDeny,
  output logic              statStart
);

  wpStrobe_t stb;
  logic      wen, wpen, inProt;

  eeprom_wprot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .cmdWrDis  (cmdWrDis),
    .cmdRdStat (cmdRdStat),
    .cmdWrStat (cmdWrStat),
    .cmdProg   (cmdProg),
    .busy      (busy),
    .wpPin     (wpPin),
    .wenIn     (wen),
    .wpenIn    (wpen),
    .inProt    (inProt),
    .stb       (stb),
    .progGrant (progGrant),
    .progDeny  (progDeny),
    .statStart (statStart)
  );

  eeprom_wprot_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .statData  (statData),
    .progAddr  (progAddr),
    .wen       (wen),
    .wpen      (wpen),
    .inProt    (inProt),
    .statusOut (statusOut)
  );

endmodule

// File: tb/eeprom_wprot_test.sv
module eeprom_wprot_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 14;
  localparam int NVEC       = 30;

  localparam logic [2:0] OP_NOP = 3'd0, OP_WEN = 3'd1, OP_WDI = 3'd2,
                         OP_RDS = 3'd3, OP_WRS = 3'd4, OP_PRG = 3'd5;

  // {op[3], addr[14], data[8], wp, busy, expGrant, expDeny, expStart, expStat[8]}
  localparam logic [37:0] VECS [0:NVEC-1] = '{
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h02},  // R2
    {OP_PRG, 14'h3FFF, 8'h00, 1'b1, 1'b0, 3'b100, 8'h00},  // R7 level 00, R8
    {OP_PRG, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b010, 8'h00},  // R6
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h02},
    {OP_WRS, 14'h0000, 8'h84, 1'b1, 1'b0, 3'b001, 8'h84},  // R9
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h86},
    {OP_PRG, 14'h3000, 8'h00, 1'b1, 1'b0, 3'b010, 8'h84},  // R7 quarter
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h86},
    {OP_PRG, 14'h2FFF, 8'h00, 1'b1, 1'b0, 3'b100, 8'h84},  // R7 quarter edge
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h86},
    {OP_WRS, 14'h0000, 8'h08, 1'b0, 1'b0, 3'b000, 8'h84},  // R10 refused
    {OP_WEN, 14'h0000, 8'h00, 1'b0, 1'b0, 3'b000, 8'h86},
    {OP_PRG, 14'h2FFF, 8'h00, 1'b0, 1'b0, 3'b100, 8'h84},  // R10 array by level only
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h86},
    {OP_WRS, 14'h0000, 8'h08, 1'b1, 1'b0, 3'b001, 8'h08},  // R9 pin high
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0A},
    {OP_PRG, 14'h2000, 8'h00, 1'b1, 1'b0, 3'b010, 8'h08},  // R7 half
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0A},
    {OP_PRG, 14'h1FFF, 8'h00, 1'b1, 1'b0, 3'b100, 8'h08},  // R7 half edge
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0A},
    {OP_WDI, 14'h0000, 8'h00, 1'b0, 1'b0, 3'b000, 8'h08},  // R3 pin low
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b1, 3'b000, 8'hFF},  // R11, R5
    {OP_NOP, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h08},  // R11 latch untouched
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0A},
    {OP_PRG, 14'h1000, 8'h00, 1'b1, 1'b1, 3'b000, 8'hFF},  // R11 no result
    {OP_NOP, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0A},  // R11 latch kept
    {OP_WRS, 14'h0000, 8'h0C, 1'b1, 1'b0, 3'b001, 8'h0C},
    {OP_WEN, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0E},
    {OP_PRG, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b010, 8'h0C},  // R7 full
    {OP_WRS, 14'h0000, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0C}   // R9 latch clear
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdWrEn, cmdWrDis, cmdRdStat, cmdWrStat, cmdProg;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0]        statData;
  logic              wpPin, busy;
  logic [7:0]        statusOut;
  logic              progGrant, progDeny, statStart;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wprot #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis), .cmdRdStat(cmdRdStat),
    .cmdWrStat(cmdWrStat), .cmdProg(cmdProg),
    .progAddr(progAddr), .statData(statData), .wpPin(wpPin), .busy(busy),
    .statusOut(statusOut), .progGrant(progGrant), .progDeny(progDeny),
    .statStart(statStart)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clearIns();
    {cmdWrEn, cmdWrDis, cmdRdStat, cmdWrStat, cmdProg} = '0;
  endtask

  // Apply strobes for one cycle, then read status; check pulses and status
  task automatic step(input string req, input logic [4:0] strobes,
                      input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input logic wp, input logic bsy,
                      input logic [2:0] expRes, input logic [7:0] expStat);
    {cmdWrEn, cmdWrDis, cmdRdStat, cmdWrStat, cmdProg} = strobes;
    progAddr = a; statData = d; wpPin = wp; busy = bsy;
    @(negedge clk);
    check(req, {5'b0, progGrant, progDeny, statStart}, {5'b0, expRes});
    clearIns();
    cmdRdStat = 1'b1;
    @(negedge clk);
    check(req, statusOut, expStat);
    cmdRdStat = 1'b0;
    busy = 1'b0;
  endtask

  function automatic logic [4:0] opStrobes(input logic [2:0] op);
    case (op)
      OP_WEN:  return 5'b10000;
      OP_WDI:  return 5'b01000;
      OP_RDS:  return 5'b00100;
      OP_WRS:  return 5'b00010;
      OP_PRG:  return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    clearIns();
    progAddr = '0; statData = '0; wpPin = 1'b1; busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", statusOut, 8'h00);
    check("R1", {5'b0, progGrant, progDeny, statStart}, 8'h00);
    rstN = 1'b1;
    step("R1", 5'b00000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      logic [37:0] e;
      e = VECS[v];
      step($sformatf("R4 vec%0d", v), opStrobes(e[37:35]), e[34:21], e[20:13],
           e[12], e[11], e[10:8], e[7:0]);
    end

    // R12: disable beats enable (state: level 11, wpen 0, latch clear)
    step("R12", 5'b11000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0C);
    // R12: enable beats program, latch stays set, no result
    step("R12", 5'b10000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0E);
    step("R12", 5'b10001, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h0E);
    // R12: write-status beats program
    step("R12", 5'b00011, '0, 8'h00, 1'b1, 1'b0, 3'b001, 8'h00);
    // R4: filler bits of the written value never show
    step("R4", 5'b10000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h02);
    step("R4", 5'b00010, '0, 8'hFF, 1'b1, 1'b0, 3'b001, 8'h8C);
    // R3: disable with pin high
    step("R3", 5'b10000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h8E);
    step("R3", 5'b01000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h8C);
    // R11: write-status during busy ignored
    step("R11", 5'b10000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h8E);
    step("R11", 5'b00010, '0, 8'h00, 1'b1, 1'b1, 3'b000, 8'hFF);
    step("R11", 5'b00000, '0, 8'h00, 1'b1, 1'b0, 3'b000, 8'h8E);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule